// File: doc/BRIEF.md
# Buffered Serial Transmitter with Programmable Bit Clock

This block is one transmit channel of an asynchronous serial port. The host writes bytes through a small register port. Each byte waits in a holding stage, which is one byte deep or, when the deep mode is selected, a `FIFO_DEPTH`-entry queue. A shifter then sends it as a frame on the `txd` line: a low start bit, 5 to 8 data bits with the least-significant bit first, an optional parity bit, and one or two high stop bits. Character format, oversampling rate (8x or 16x), divisor and a divide-by-4 prescaler are all set through registers.

The bit clock comes from a `DIV_W`-bit divisor. A zero divisor counts as 2^`DIV_W`. The prescaler and divisor counters stay cleared while the shifter is idle, so every isolated frame begins with a whole start bit. A byte that is already queued when the last stop bit ends is loaded on that same boundary, so frames run back to back with no gap.

Two status flags are provided. The holding-empty flag reports that no byte is waiting. The line-empty flag also requires the shifter to be idle. A transmit-empty interrupt is the holding-empty flag gated by an enable bit. The shifter's controller has five states:

- `TX_IDLE`: the line is high.
- `TX_START`: sends the start bit.
- `TX_DATA`: shifts out the data bits.
- `TX_PARITY`: sends the parity bit.
- `TX_STOP`: sends one or two stop bits.

The state transitions are:

- IDLE→START when a byte is available.
- START→DATA.
- DATA→PARITY after the last data bit when parity is enabled; otherwise DATA→STOP.
- PARITY→STOP.
- STOP→START when another byte is waiting.
- STOP→IDLE when no byte is waiting.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset `txd`=1, `hold_empty`=1, `shift_empty`=1 and `irq`=0. Reading address 5 returns status {5'b0, irq, shift_empty, hold_empty} = 8'h03. Reading address 3 returns the reset format 8'h03.
- R2: A write to address 0 queues a byte. Its frame is a 0 start bit followed by 5+fmt[1:0] data bits, least-significant bit first. The format register is at address 3.
- R3: When fmt[3]=1 a parity bit follows the data. With fmt[4]=1 it equals the XOR of the sent data bits (even parity); with fmt[4]=0 it is that XOR's inverse (odd parity).
- R4: The frame ends with one stop bit (fmt[2]=0) or two stop bits (fmt[2]=1), both at level 1.
- R5: One bit lasts OS×D×P clock cycles. OS is 8 when ctrl[2]=1 and 16 otherwise. D is the divisor {addr2, addr1} truncated to DIV_W bits. P is 4 when ctrl[3]=1 and 1 otherwise. The control register is at address 4.
- R6: A divisor of 0 acts as 2^DIV_W.
- R7: With ctrl[0]=0 the holding stage holds one byte. `hold_empty` falls on the cycle after an accepted write and rises when the byte moves into the shifter.
- R8: With ctrl[0]=1 up to FIFO_DEPTH bytes wait and are sent in write order. In either mode a write while the holding stage is full is dropped and leaves the queued bytes unchanged.
- R9: `shift_empty` is 1 only when the shifter is idle and no byte waits. It stays 0 through the last stop bit.
- R10: A byte waiting when the last stop bit ends starts its start bit on that same cycle, so successive frames are exactly frame-length apart.
- R11: `irq` equals ctrl[1] AND `hold_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 data, 1 divisor low, 2 divisor high, 3 format, 4 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address (1 to 4 as written, 5 status) |
| rd_data | output | 8 | Combinational read data |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | No byte waiting in the holding stage |
| shift_empty | output | 1 | Holding stage empty and shifter idle |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
The bench builds the block with FIFO_DEPTH=4 and DIV_W=8. The shallow queue lets a burst of six writes reach the full-and-drop case within a single frame. The narrow divisor makes the zero-divisor wrap a 2048-cycle bit at 8x, short enough to measure directly. With the divisor at 1 and 8x sampling a bit is eight cycles. This makes it cheap to sweep all 24 format combinations and all 256 byte values back to back, checking every bit at mid-bit and every frame-to-frame spacing.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    localparam logic [2:0] ADDR_DATA   = 3'd0;
    localparam logic [2:0] ADDR_DIV_LO = 3'd1;
    localparam logic [2:0] ADDR_DIV_HI = 3'd2;
    localparam logic [2:0] ADDR_FORMAT = 3'd3;
    localparam logic [2:0] ADDR_CTRL   = 3'd4;
    localparam logic [2:0] ADDR_STATUS = 3'd5;

    // format register: [4] even parity, [3] parity on, [2] two stops, [1:0] length-5
    typedef struct packed {
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len;
    } frame_fmt_t;

    // control register: [3] prescale, [2] 8x, [1] irq enable, [0] deep queue
    typedef struct packed {
        logic presc;
        logic os8;
        logic irq_en;
        logic deep;
    } chan_ctrl_t;

    localparam frame_fmt_t FMT_RESET = '{even: 1'b0, par_en: 1'b0, two_stop: 1'b0, len: 2'd3};

    function automatic logic [7:0] len_mask(input logic [1:0] len);
        logic [7:0] m;
        unique case (len)
            2'd0: m = 8'h1F;
            2'd1: m = 8'h3F;
            2'd2: m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W    = 16,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             presc_en,
    input  logic             os8,
    output logic             bit_tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] cnt_q;
    logic [3:0]       sub_q;
    logic             step;
    logic             samp;
    logic [3:0]       sub_last;

    // zero divisor wraps to all ones, giving a full 2^DIV_W count
    always_comb begin
        step     = !presc_en || (pre_q == PRE_LAST);
        samp     = step && (cnt_q == (div - DIV_W'(1)));
        sub_last = os8 ? 4'd7 : 4'd15;
        bit_tick = samp && (sub_q == sub_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
            sub_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
            cnt_q <= '0;
            sub_q <= '0;
        end else begin
            if (presc_en) begin
                pre_q <= step ? '0 : pre_q + PRE_W'(1);
            end
            if (step) begin
                cnt_q <= samp ? '0 : cnt_q + DIV_W'(1);
            end
            if (samp) begin
                sub_q <= (sub_q == sub_last) ? 4'd0 : sub_q + 4'd1;
            end
        end
    end
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         deep_en,
    input  logic                         push,
    input  logic [7:0]                   din,
    input  logic                         pop,
    output logic [7:0]                   dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          do_push;
    logic          do_pop;

    always_comb begin
        limit   = deep_en ? CW'(DEPTH) : CW'(1);
        full    = (cnt_q >= limit);
        empty   = (cnt_q == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr_q];
        count   = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + AW'(1);
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + AW'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       avail,
    input  logic [7:0] din,
    input  frame_fmt_t fmt,
    output logic       pop,
    output logic       run,
    output logic       txd,
    output tx_state_e  state
);
    tx_state_e  state_q;
    tx_state_e  state_d;
    frame_fmt_t fmt_q;
    logic [7:0] shreg_q;
    logic [2:0] bit_idx_q;
    logic       stop_idx_q;
    logic       par_q;
    logic       last_data;
    logic       last_stop;
    logic       load;

    always_comb begin
        last_data = (bit_idx_q == (3'd4 + {1'b0, fmt_q.len}));
        last_stop = !fmt_q.two_stop || stop_idx_q;
        load      = avail && ((state_q == TX_IDLE) ||
                              (state_q == TX_STOP && bit_tick && last_stop));
        pop       = load;
        run       = (state_q != TX_IDLE);
        state     = state_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (avail) state_d = TX_START;
            TX_START:  if (bit_tick) state_d = TX_DATA;
            TX_DATA:   if (bit_tick && last_data) state_d = fmt_q.par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_tick) state_d = TX_STOP;
            TX_STOP:   if (bit_tick && last_stop) state_d = avail ? TX_START : TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q      <= FMT_RESET;
            shreg_q    <= '0;
            bit_idx_q  <= '0;
            stop_idx_q <= 1'b0;
            par_q      <= 1'b0;
        end else if (load) begin
            fmt_q      <= fmt;
            shreg_q    <= din;
            bit_idx_q  <= '0;
            stop_idx_q <= 1'b0;
            par_q      <= (^(din & len_mask(fmt.len))) ^ ~fmt.even;
        end else if (bit_tick) begin
            if (state_q == TX_DATA) begin
                shreg_q   <= {1'b0, shreg_q[7:1]};
                bit_idx_q <= bit_idx_q + 3'd1;
            end
            if (state_q == TX_STOP) begin
                stop_idx_q <= 1'b1;
            end
        end
    end

    // line output
    always_comb begin
        unique case (state_q)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg_q[0];
            TX_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int DIV_W      = 16,
    parameter int PRESCALE   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       txd,
    output logic       hold_empty,
    output logic       shift_empty,
    output logic       irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [7:0]  div_lo_q;
    logic [7:0]  div_hi_q;
    frame_fmt_t  fmt_q;
    chan_ctrl_t  ctrl_q;
    logic [15:0] div_full;
    logic [DIV_W-1:0] div_eff;

    logic          push;
    logic          pop;
    logic [7:0]    q_dout;
    logic          q_empty;
    logic          q_full;
    logic [CW-1:0] q_count;
    logic          run;
    logic          bit_tick;
    tx_state_e     sh_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_lo_q <= 8'd1;
            div_hi_q <= 8'd0;
            fmt_q    <= FMT_RESET;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_DIV_LO: div_lo_q <= wr_data;
                ADDR_DIV_HI: div_hi_q <= wr_data;
                ADDR_FORMAT: fmt_q    <= frame_fmt_t'(wr_data[4:0]);
                ADDR_CTRL:   ctrl_q   <= chan_ctrl_t'(wr_data[3:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        push     = wr_en && (wr_addr == ADDR_DATA);
        div_full = {div_hi_q, div_lo_q};
        div_eff  = div_full[DIV_W-1:0];
    end

    uart_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .deep_en (ctrl_q.deep),
        .push    (push),
        .din     (wr_data),
        .pop     (pop),
        .dout    (q_dout),
        .empty   (q_empty),
        .full    (q_full),
        .count   (q_count)
    );

    uart_tx_baud #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div      (div_eff),
        .presc_en (ctrl_q.presc),
        .os8      (ctrl_q.os8),
        .bit_tick (bit_tick)
    );

    uart_tx_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .avail    (!q_empty),
        .din      (q_dout),
        .fmt      (fmt_q),
        .pop      (pop),
        .run      (run),
        .txd      (txd),
        .state    (sh_state)
    );

    always_comb begin
        hold_empty  = q_empty;
        shift_empty = q_empty && (sh_state == TX_IDLE);
        irq         = ctrl_q.irq_en && q_empty;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_DIV_LO: rd_data = div_lo_q;
            ADDR_DIV_HI: rd_data = div_hi_q;
            ADDR_FORMAT: rd_data = {3'b000, fmt_q};
            ADDR_CTRL:   rd_data = {4'b0000, ctrl_q};
            ADDR_STATUS: rd_data = {5'b00000, irq, shift_empty, hold_empty};
            default:     rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/uart_tx_chan_chk.sv
module uart_tx_chan_chk
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       txd,
    input logic                       hold_empty,
    input logic                       shift_empty,
    input logic                       irq,
    input logic                       push,
    input logic                       pop,
    input logic                       full,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input tx_state_e                  sh_state
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_state == TX_START) |-> !txd);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ($clog2(DEPTH+1))'(DEPTH));

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

    assert_busy_not_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_state != TX_IDLE) |-> !shift_empty);

    assert_stop_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sh_state) == TX_STOP && sh_state != TX_STOP) |-> (sh_state == TX_START || sh_state == TX_IDLE));

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hold_empty);
endmodule

bind uart_tx_chan uart_tx_chan_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty),
    .irq         (irq),
    .push        (push),
    .pop         (pop),
    .full        (q_full),
    .count       (q_count),
    .sh_state    (sh_state)
);

// File: tb/uart_tx_chan_tb.sv
`timescale 1ns/1ps
module uart_tx_chan_tb;
    localparam int DEPTH = 4;
    localparam int DW    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       txd;
    logic       hold_empty;
    logic       shift_empty;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int B      = 16;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tx_chan #(.FIFO_DEPTH(DEPTH), .DIV_W(DW), .PRESCALE(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .txd(txd), .hold_empty(hold_empty),
        .shift_empty(shift_empty), .irq(irq)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (ok !== 1'b1) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [4:0] f, input logic [3:0] c, input logic [7:0] dv);
        int lim;
        wr(3'd3, {3'b0, f});
        wr(3'd4, {4'b0, c});
        wr(3'd1, dv);
        wr(3'd2, 8'h00);
        lim = (dv == 0) ? 256 : int'(dv);
        B = (c[2] ? 8 : 16) * lim * (c[3] ? 4 : 1);
    endtask

    function automatic int frame_len(input logic [4:0] f);
        return 1 + 5 + int'(f[1:0]) + int'(f[3]) + 1 + int'(f[2]);
    endfunction

    function automatic logic [11:0] frame_bits(input logic [7:0] d, input logic [4:0] f);
        logic [11:0] b = '1;
        int nd = 5 + int'(f[1:0]);
        logic x = 1'b0;
        b[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            b[1 + i] = d[i];
            x = x ^ d[i];
        end
        if (f[3]) b[1 + nd] = f[4] ? x : ~x;
        return b;
    endfunction

    task automatic wait_fall(output int t);
        while (txd !== 1'b0) @(negedge clk);
        t = cyc;
    endtask

    task automatic rx_frame(input logic [7:0] d, input logic [4:0] f, input string tag, output int t);
        int n = frame_len(f);
        logic [11:0] bits = frame_bits(d, f);
        wait_fall(t);
        repeat (B / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i != 0) repeat (B) @(negedge clk);
            check(txd === bits[i], tag, int'(txd), int'(bits[i]));
        end
    endtask

    task automatic wait_idle();
        while (shift_empty !== 1'b1) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic measure(input string tag, input int exp);
        int lo = 0;
        wr(3'd0, 8'hFF);
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin
            lo++;
            @(negedge clk);
        end
        check(lo == exp, tag, lo, exp);
        wait_idle();
    endtask

    initial begin
        wait (cyc >= 190000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int t0, t1, hi_bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(txd === 1'b1, "R1 txd", int'(txd), 1);
        check(hold_empty === 1'b1, "R1 hold_empty", int'(hold_empty), 1);
        check(shift_empty === 1'b1, "R1 shift_empty", int'(shift_empty), 1);
        check(irq === 1'b0, "R1 irq", int'(irq), 0);
        rd_addr = 3'd5; #0.1;
        check(rd_data === 8'h03, "R1 status read", int'(rd_data), 3);
        rd_addr = 3'd3; #0.1;
        check(rd_data === 8'h03, "R1 format read", int'(rd_data), 3);

        // R7 R9 R8 R10: single-byte holding stage, 8N1, 16x, divisor 1
        set_cfg(5'b00011, 4'b0000, 8'd1);
        fork
            begin
                wr(3'd0, 8'h3C);
                check(hold_empty === 1'b0, "R7 hold after write", int'(hold_empty), 0);
                check(shift_empty === 1'b0, "R9 busy after write", int'(shift_empty), 0);
                @(negedge clk);
                check(hold_empty === 1'b1, "R7 hold after load", int'(hold_empty), 1);
                check(shift_empty === 1'b0, "R9 shifter busy", int'(shift_empty), 0);
                wr(3'd0, 8'hC5);
                check(hold_empty === 1'b0, "R7 second held", int'(hold_empty), 0);
                wr(3'd0, 8'h99);
            end
            begin
                rx_frame(8'h3C, 5'b00011, "R2 hold byte0", t0);
                rx_frame(8'hC5, 5'b00011, "R8 drop keeps byte1", t1);
                check(t1 - t0 == 10 * B, "R10 no gap", t1 - t0, 10 * B);
                check(shift_empty === 1'b0, "R9 low in stop bit", int'(shift_empty), 0);
                repeat (B / 2 + 1) @(negedge clk);
                check(shift_empty === 1'b1, "R9 empty after stop", int'(shift_empty), 1);
            end
        join
        hi_bad = 0;
        repeat (3 * B) begin
            @(negedge clk);
            if (txd !== 1'b1) hi_bad++;
        end
        check(hi_bad == 0, "R8 dropped byte not sent", hi_bad, 0);

        // R11 interrupt gating
        check(irq === 1'b0, "R11 masked", int'(irq), 0);
        wr(3'd4, 8'h02);
        check(irq === 1'b1, "R11 enabled empty", int'(irq), 1);
        fork
            begin
                wr(3'd0, 8'h5A);
                check(irq === 1'b0, "R11 low when held", int'(irq), 0);
            end
            rx_frame(8'h5A, 5'b00011, "R11 frame", t0);
        join
        wait_idle();
        check(irq === 1'b1, "R11 high after send", int'(irq), 1);

        // R2 R3 R4 R10 sweep over every format at 8x, divisor 1
        for (int f = 0; f < 24; f++) begin
            logic [1:0] ln = 2'(f % 4);
            int pm = (f / 4) % 3;
            logic two = (f >= 12);
            logic [4:0] fm = {pm == 2, pm != 0, two, ln};
            logic [7:0] d0 = 8'(8'hA5 ^ (f * 37));
            logic [7:0] d1 = 8'(8'h3B + f * 11);
            set_cfg(fm, 4'b0100, 8'd1);
            fork
                begin
                    wr(3'd0, d0);
                    wr(3'd0, d1);
                end
                begin
                    rx_frame(d0, fm, "R2/R3/R4 frame a", t0);
                    rx_frame(d1, fm, "R2/R3/R4 frame b", t1);
                    check(t1 - t0 == frame_len(fm) * B, "R10 gap sweep", t1 - t0, frame_len(fm) * B);
                end
            join
            wait_idle();
        end

        // R2 R10 all byte values streamed through the deep queue
        set_cfg(5'b00011, 4'b0101, 8'd1);
        fork
            for (int v = 0; v < 256; v++) begin
                while (hold_empty !== 1'b1) @(negedge clk);
                wr(3'd0, 8'(v));
            end
            begin
                int prev = 0;
                for (int v = 0; v < 256; v++) begin
                    rx_frame(8'(v), 5'b00011, "R2 byte sweep", t1);
                    if (v != 0) check(t1 - prev == 10 * B, "R10 stream gap", t1 - prev, 10 * B);
                    prev = t1;
                end
            end
        join
        wait_idle();

        // R8 burst of six into a four-deep queue
        fork
            begin
                for (int k = 0; k < 6; k++) wr(3'd0, 8'(8'h10 + k * 17));
                check(hold_empty === 1'b0, "R8 queue held", int'(hold_empty), 0);
            end
            for (int k = 0; k < 5; k++) rx_frame(8'(8'h10 + k * 17), 5'b00011, "R8 queue order", t0);
        join
        hi_bad = 0;
        repeat (3 * 10 * B) begin
            @(negedge clk);
            if (txd !== 1'b1) hi_bad++;
        end
        check(hi_bad == 0, "R8 sixth byte dropped", hi_bad, 0);
        check(shift_empty === 1'b1, "R9 empty after burst", int'(shift_empty), 1);

        // R5 R6 bit time
        set_cfg(5'b00011, 4'b0000, 8'd3);
        measure("R5 16x div3", 48);
        set_cfg(5'b00011, 4'b1100, 8'd5);
        measure("R5 8x div5 prescale", 160);
        set_cfg(5'b00011, 4'b1000, 8'd2);
        measure("R5 16x div2 prescale", 128);
        set_cfg(5'b00011, 4'b0100, 8'd0);
        measure("R6 divisor zero", 2048);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule